// File: doc/BRIEF.md
# Auto-Retransmit and Interrupt Controller

This block is the transmit-side link controller of a packet radio. A send request launches a transmission strobe toward the radio. When the radio reports the end of the on-air transmission, the controller either treats the packet as delivered at once or waits for an acknowledge, depending on configuration. If no acknowledge arrives within a programmable wait, it launches the packet again. It repeats this up to a programmable number of times and then gives up.

The block keeps three sticky event flags: data ready, data sent and retries exhausted. Each flag can be masked from a shared active-low interrupt line, and software clears a flag by writing a one to its bit. The block also counts the retransmissions of the current packet and keeps a saturating count of lost packets. That loss count is cleared by any write to the 7-bit channel register, which the block also holds. Time is measured by a one-microsecond tick input.

Top module: `arc_link_ctrl`

## Requirements
- R1: After a transmission ends (tx_done sampled) with no acknowledge, the next retransmit strobe starts after (cfg_delay+1)*250+86 microsecond ticks. With us_tick high every cycle, tx_start rises in the cycle (cfg_delay+1)*250+86 clock edges after the edge that sampled tx_done.
- R2: cfg_retries = 0 means no retransmission. A value N from 1 to 15 allows at most N retransmissions, so at most N+1 strobes per packet.
- R3: With cfg_ack_en = 0, the data-sent flag (bit 1) is set when tx_done is sampled. With cfg_ack_en = 1, it is set only when ack_rx is sampled while the controller is waiting. The data-ready flag (bit 2) is set when rx_data is sampled.
- R4: When the wait after the last allowed attempt expires with no acknowledge, the max-retry flag (bit 0) is set. While that flag is set, send_req is ignored and no tx_start is produced.
- R5: A cycle with stat_wr high clears every flag whose stat_wdata bit is 1 and leaves the other flags unchanged. A flag set event in the same cycle wins over its clear.
- R6: irq_n is low exactly when some flag is set and its cfg_mask bit (same bit position) is 0.
- R7: retry_cnt returns to 0 when a new packet is accepted and increases by one at each retransmission.
- R8: lost_cnt increments each time a packet exhausts its retries, holds at 15, and returns to 0 on any chan_wr.
- R9: chan_wr stores chan_wdata (0 to 127) into channel.
- R10: If ack_rx arrives in the same cycle as the wait expires, the packet counts as delivered. The data-sent flag is set and no retransmission occurs.
- R11: After reset, flags are 0, irq_n is 1, retry_cnt and lost_cnt are 0, channel is 2 and tx_start is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| send_req | input | 1 | Request to send a new packet |
| tx_done | input | 1 | Radio reports end of on-air transmission |
| ack_rx | input | 1 | Acknowledge received strobe |
| rx_data | input | 1 | Payload received strobe |
| us_tick | input | 1 | One-microsecond time base pulse |
| cfg_delay | input | 4 | Retransmit wait code |
| cfg_retries | input | 4 | Maximum retransmissions |
| cfg_ack_en | input | 1 | Wait for acknowledge when 1 |
| cfg_mask | input | 3 | Interrupt mask per flag, 1 = masked |
| stat_wr | input | 1 | Flag clear write strobe |
| stat_wdata | input | 3 | Write-one-to-clear flag bits |
| chan_wr | input | 1 | Channel register write strobe |
| chan_wdata | input | 7 | Channel value to write |
| tx_start | output | 1 | One-cycle strobe to launch a transmission |
| flags | output | 3 | {data ready, data sent, max retry} |
| irq_n | output | 1 | Active-low interrupt |
| retry_cnt | output | 4 | Retransmissions of the current packet |
| lost_cnt | output | 4 | Saturating lost-packet count |
| channel | output | 7 | Channel register |

## Verification
Several properties are checked on every cycle. No strobe may follow a cycle that is idle with the max-retry flag up, or a cycle in which an acknowledge reached the waiting state. The retry count never exceeds its limit at a strobe, and the loss counter both saturates and clears on a channel write. A newly set flag always survives a same-cycle clear, and the wait counter never passes its limit. The length of each wait, the number of strobes for each mix of retry count and acknowledge timing, the mask behaviour of the interrupt line and the exact-cycle acknowledge race are shown only by the bench scenarios, which compare the outputs against values computed from the requirements.

// File: rtl/arc_pkg.sv
package arc_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_WAIT} arc_state_e;

  localparam int FLAG_MAX  = 0;
  localparam int FLAG_SENT = 1;
  localparam int FLAG_RX   = 2;
  localparam int NFLAGS    = 3;

  // Wait length in microseconds for a given delay code.
  function automatic int unsigned wait_us(input int unsigned code,
                                          input int unsigned step,
                                          input int unsigned base);
    return (code + 1) * step + base;
  endfunction
endpackage

// File: rtl/arc_delay_timer.sv
module arc_delay_timer #(
  parameter int DLY_W   = 4,
  parameter int STEP_US = 250,
  parameter int BASE_US = 86,
  parameter int TMR_W   = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  input  logic             tick,
  input  logic [DLY_W-1:0] code,
  output logic             expire
);
  import arc_pkg::*;

  logic [TMR_W-1:0] cnt;
  logic [TMR_W-1:0] limit;

  assign limit  = TMR_W'(wait_us(int'(unsigned'(code)), STEP_US, BASE_US));
  assign expire = run && tick && (cnt == limit - TMR_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt <= '0;
    else if (start)                cnt <= '0;
    else if (run && tick && !expire) cnt <= cnt + TMR_W'(1);
  end

  AST_TMR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt < limit); // R1
endmodule

// File: rtl/arc_flags.sv
module arc_flags #(
  parameter int NF = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set,
  input  logic          clr_wr,
  input  logic [NF-1:0] clr_bits,
  input  logic [NF-1:0] mask,
  output logic [NF-1:0] flags,
  output logic          irq_n
);
  logic [NF-1:0] clr_eff;

  assign clr_eff = clr_wr ? clr_bits : '0;
  assign irq_n   = ~|(flags & ~mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr_eff) | set;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|set) |=> ((flags & $past(set)) == $past(set))); // R5
endmodule

// File: rtl/arc_counters.sv
module arc_counters #(
  parameter int               CNT_W  = 4,
  parameter int               CH_W   = 7,
  parameter logic [CH_W-1:0]  CH_RST = 7'd2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             new_pkt,
  input  logic             retry_inc,
  input  logic             fail,
  input  logic             chan_wr,
  input  logic [CH_W-1:0]  chan_wdata,
  output logic [CNT_W-1:0] retry_cnt,
  output logic [CNT_W-1:0] lost_cnt,
  output logic [CH_W-1:0]  channel
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         retry_cnt <= '0;
    else if (new_pkt)   retry_cnt <= '0;
    else if (retry_inc) retry_cnt <= retry_cnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          lost_cnt <= '0;
    else if (chan_wr)                    lost_cnt <= '0;
    else if (fail && lost_cnt != CNT_MAX) lost_cnt <= lost_cnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       channel <= CH_RST;
    else if (chan_wr) channel <= chan_wdata;
  end

  AST_LOST_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (lost_cnt == CNT_MAX && !chan_wr) |=> lost_cnt == CNT_MAX); // R8
  AST_LOST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    chan_wr |=> lost_cnt == '0); // R8
endmodule

// File: rtl/arc_link_ctrl.sv
module arc_link_ctrl #(
  parameter int DLY_W   = 4,
  parameter int CNT_W   = 4,
  parameter int CH_W    = 7,
  parameter int STEP_US = 250,
  parameter int BASE_US = 86,
  parameter int CH_RST  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             send_req,
  input  logic             tx_done,
  input  logic             ack_rx,
  input  logic             rx_data,
  input  logic             us_tick,
  input  logic [DLY_W-1:0] cfg_delay,
  input  logic [CNT_W-1:0] cfg_retries,
  input  logic             cfg_ack_en,
  input  logic [2:0]       cfg_mask,
  input  logic             stat_wr,
  input  logic [2:0]       stat_wdata,
  input  logic             chan_wr,
  input  logic [CH_W-1:0]  chan_wdata,
  output logic             tx_start,
  output logic [2:0]       flags,
  output logic             irq_n,
  output logic [CNT_W-1:0] retry_cnt,
  output logic [CNT_W-1:0] lost_cnt,
  output logic [CH_W-1:0]  channel
);
  import arc_pkg::*;

  localparam int TMR_W = $clog2((2 ** DLY_W) * STEP_US + BASE_US + 1);

  arc_state_e state, state_nx;

  // Named internal events
  logic accept_ev, done_ev, ack_ev, expire_ev, retry_ev, give_up_ev, sent_ev;
  logic [NFLAGS-1:0] set_vec;

  assign accept_ev  = (state == ST_IDLE) && send_req && !flags[FLAG_MAX];
  assign done_ev    = (state == ST_SEND) && tx_done;
  assign ack_ev     = (state == ST_WAIT) && ack_rx;
  assign retry_ev   = expire_ev && !ack_ev && (retry_cnt < cfg_retries);
  assign give_up_ev = expire_ev && !ack_ev && (retry_cnt >= cfg_retries);
  assign sent_ev    = (done_ev && !cfg_ack_en) || ack_ev;

  always_comb begin
    set_vec            = '0;
    set_vec[FLAG_MAX]  = give_up_ev;
    set_vec[FLAG_SENT] = sent_ev;
    set_vec[FLAG_RX]   = rx_data;
  end

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE: if (accept_ev) state_nx = ST_SEND;
      ST_SEND: if (done_ev)   state_nx = cfg_ack_en ? ST_WAIT : ST_IDLE;
      ST_WAIT: begin
        if (ack_ev || give_up_ev) state_nx = ST_IDLE;
        else if (retry_ev)        state_nx = ST_SEND;
      end
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      tx_start <= 1'b0;
    end else begin
      state    <= state_nx;
      tx_start <= accept_ev || retry_ev;
    end
  end

  arc_delay_timer #(
    .DLY_W(DLY_W), .STEP_US(STEP_US), .BASE_US(BASE_US), .TMR_W(TMR_W)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .start(done_ev), .run(state == ST_WAIT),
    .tick(us_tick), .code(cfg_delay), .expire(expire_ev)
  );

  arc_flags #(.NF(NFLAGS)) u_flags (
    .clk(clk), .rst_n(rst_n), .set(set_vec), .clr_wr(stat_wr),
    .clr_bits(stat_wdata), .mask(cfg_mask), .flags(flags), .irq_n(irq_n)
  );

  arc_counters #(
    .CNT_W(CNT_W), .CH_W(CH_W), .CH_RST(CH_W'(CH_RST))
  ) u_cnt (
    .clk(clk), .rst_n(rst_n), .new_pkt(accept_ev), .retry_inc(retry_ev),
    .fail(give_up_ev), .chan_wr(chan_wr), .chan_wdata(chan_wdata),
    .retry_cnt(retry_cnt), .lost_cnt(lost_cnt), .channel(channel)
  );

  AST_NO_SEND_WHILE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && flags[FLAG_MAX]) |=> !tx_start); // R4
  AST_ACK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && ack_rx) |=> !tx_start); // R10
  AST_RETRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> retry_cnt <= cfg_retries); // R2
  AST_MAX_FROM_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[FLAG_MAX]) |-> $past(state) == ST_WAIT); // R4
endmodule

// File: tb/sim_arc_link_ctrl.sv
module sim_arc_link_ctrl;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [3:0] dly;
    logic [3:0] cnt;
    logic       en;
    logic [3:0] ack_at;
    logic [3:0] attempts;
    logic       sent;
    logic       maxf;
    logic [3:0] retries;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{4'd0, 4'd3, 1'b1, 4'd2, 4'd2, 1'b1, 1'b0, 4'd1},
    '{4'd1, 4'd2, 1'b1, 4'd0, 4'd3, 1'b0, 1'b1, 4'd2},
    '{4'd0, 4'd0, 1'b1, 4'd0, 4'd1, 1'b0, 1'b1, 4'd0},
    '{4'd0, 4'd5, 1'b0, 4'd0, 4'd1, 1'b1, 1'b0, 4'd0},
    '{4'd2, 4'd1, 1'b1, 4'd1, 4'd1, 1'b1, 1'b0, 4'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic send_req = 0, tx_done = 0, ack_rx = 0, rx_data = 0, us_tick = 1;
  logic [3:0] cfg_delay = 0, cfg_retries = 0;
  logic cfg_ack_en = 0;
  logic [2:0] cfg_mask = 0;
  logic stat_wr = 0;
  logic [2:0] stat_wdata = 0;
  logic chan_wr = 0;
  logic [6:0] chan_wdata = 0;
  logic tx_start, irq_n;
  logic [2:0] flags;
  logic [3:0] retry_cnt, lost_cnt;
  logic [6:0] channel;

  int n_chk = 0, n_bad = 0, exp_lost = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  arc_link_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .send_req(send_req), .tx_done(tx_done),
    .ack_rx(ack_rx), .rx_data(rx_data), .us_tick(us_tick),
    .cfg_delay(cfg_delay), .cfg_retries(cfg_retries), .cfg_ack_en(cfg_ack_en),
    .cfg_mask(cfg_mask), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
    .chan_wr(chan_wr), .chan_wdata(chan_wdata), .tx_start(tx_start),
    .flags(flags), .irq_n(irq_n), .retry_cnt(retry_cnt), .lost_cnt(lost_cnt),
    .channel(channel)
  );

  function automatic int wait_of(input int code);
    return 250 * code + 336;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_flags();
    stat_wdata = 3'b111; stat_wr = 1; @(negedge clk); stat_wr = 0;
  endtask

  // Runs one packet; us_tick is high every cycle.
  task automatic run_pkt(input vec_t v, output int att, output int gap1);
    bit fin;
    int n;
    att = 0; gap1 = -1; fin = 0;
    cfg_delay = v.dly; cfg_retries = v.cnt; cfg_ack_en = v.en;
    send_req = 1; @(negedge clk); send_req = 0;
    while (!fin) begin
      if (!tx_start) begin
        fin = 1;
      end else begin
        att++;
        repeat (3) @(negedge clk);
        tx_done = 1; @(negedge clk); tx_done = 0;
        if (!v.en) fin = 1;
        else if (int'(v.ack_at) == att) begin
          repeat (2) @(negedge clk);
          ack_rx = 1; @(negedge clk); ack_rx = 0;
          fin = 1;
        end else begin
          n = 1;
          while (!tx_start && !flags[0] && n < 6000) begin
            @(negedge clk); n++;
          end
          if (tx_start && gap1 < 0) gap1 = n;
          if (!tx_start) fin = 1;
        end
      end
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int att, gap;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    check("R11 flags", flags, 0);
    check("R11 irq_n", irq_n, 1);
    check("R11 retry", retry_cnt, 0);
    check("R11 lost", lost_cnt, 0);
    check("R11 channel", channel, 2);
    check("R11 tx_start", tx_start, 0);

    for (int i = 0; i < NV; i++) begin
      run_pkt(VECS[i], att, gap);
      check("R2 attempts", att, VECS[i].attempts);
      check("R3 sent flag", flags[1], VECS[i].sent);
      check("R4 max flag", flags[0], VECS[i].maxf);
      check("R7 retry count", retry_cnt, VECS[i].retries);
      if (VECS[i].maxf) exp_lost++;
      check("R8 lost count", lost_cnt, exp_lost);
      if (gap >= 0) check("R1 wait", gap, wait_of(VECS[i].dly) + 1);
      clear_flags();
      check("R5 clear all", flags, 0);
    end

    // R4 / R6: max flag drives interrupt, masking, blocked send
    run_pkt('{4'd0, 4'd0, 1'b1, 4'd0, 4'd1, 1'b0, 1'b1, 4'd0}, att, gap);
    exp_lost++;
    check("R4 max set", flags[0], 1);
    check("R6 irq low", irq_n, 0);
    cfg_mask = 3'b001; @(negedge clk);
    check("R6 irq masked", irq_n, 1);
    cfg_mask = 3'b000;
    send_req = 1; @(negedge clk); send_req = 0;
    att = 0;
    for (int k = 0; k < 10; k++) begin
      if (tx_start) att++;
      @(negedge clk);
    end
    check("R4 send ignored", att, 0);
    check("R4 flag kept", flags, 1);

    // R3 rx flag, R5 selective and same-cycle clear
    rx_data = 1; @(negedge clk); rx_data = 0;
    check("R3 rx flag", flags, 3'b101);
    stat_wdata = 3'b001; stat_wr = 1; @(negedge clk); stat_wr = 0;
    check("R5 selective", flags, 3'b100);
    cfg_mask = 3'b011; @(negedge clk);
    check("R6 rx unmasked", irq_n, 0);
    cfg_mask = 3'b000;
    rx_data = 1; stat_wdata = 3'b100; stat_wr = 1; @(negedge clk);
    rx_data = 0; stat_wr = 0;
    check("R5 set wins", flags, 3'b100);
    clear_flags();
    check("R6 irq idle", irq_n, 1);

    // R10 acknowledge at the expiry cycle
    cfg_delay = 0; cfg_retries = 2; cfg_ack_en = 1;
    send_req = 1; @(negedge clk); send_req = 0;
    repeat (3) @(negedge clk);
    tx_done = 1; @(negedge clk); tx_done = 0;
    repeat (wait_of(0) - 1) @(negedge clk);
    ack_rx = 1; @(negedge clk); ack_rx = 0;
    att = 0;
    for (int k = 0; k < 5; k++) begin
      if (tx_start) att++;
      @(negedge clk);
    end
    check("R10 no retransmit", att, 0);
    check("R10 sent flag", flags, 3'b010);
    check("R10 retry", retry_cnt, 0);
    clear_flags();

    // R8 saturation and channel clear, R9 channel store
    for (int k = 0; k < 16; k++) begin
      run_pkt('{4'd0, 4'd0, 1'b1, 4'd0, 4'd1, 1'b0, 1'b1, 4'd0}, att, gap);
      clear_flags();
    end
    check("R8 saturate", lost_cnt, 15);
    chan_wdata = 7'd100; chan_wr = 1; @(negedge clk); chan_wr = 0;
    check("R8 cleared", lost_cnt, 0);
    check("R9 channel", channel, 100);
    chan_wdata = 7'd127; chan_wr = 1; @(negedge clk); chan_wr = 0;
    check("R9 channel top", channel, 127);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule